// File: doc/BRIEF.md
# Phase Slew Rate Limiter

This block sits between the phase detector and the loop filter of an all-digital PLL. On every update tick it takes a signed phase-error sample, the difference between the reference and feedback edges in picoseconds, and produces a limited phase error. The limited value follows the raw error, but it moves by no more than a fixed amount per tick. When the loop switches to a new reference, the phase step it sees therefore becomes a bounded ramp and not a sudden jump, so the switchover is hitless.

The rate is programmed in nanoseconds of phase per second as a 16-bit unsigned number. A separate scale input, derived by the integrator from the update rate, converts that rate into a per-tick step: step = (limit × scale) >> 16. A nonzero limit never gives a step below 1 ps. How closely the limiter keeps to the rate depends on the limit value and on the update rate. A limit of zero, which is the reset value, turns the limiter off: each tick loads the raw error unchanged. A synchronous clear loads the raw error at once, for use when the loop first acquires lock.

Top module: `phase_slew_limiter`

## Requirements
- R1: After reset the limited output is 0, and busy is 0 while the limit is 0.
- R2: When the rate limit is 0, each tick loads the raw phase error into the output unchanged, one clock after the tick.
- R3: The per-tick step equals (rate_limit × rate_scale) >> 16 and is forced to 1 when that product gives 0 and the limit is nonzero.
- R4: With a nonzero limit, a tick whose raw error differs from the output by more than the step moves the output by exactly one step toward the raw error, upward or downward.
- R5: With a nonzero limit, a tick whose raw error lies within one step of the output, the equal case included, makes the output equal to the raw error.
- R6: Without a tick or a clear, the output holds its value whatever the raw input does.
- R7: A clear loads the raw error into the output on the next clock edge, whether or not a tick is present and whatever the limit is, and it takes priority over a tick.
- R8: Busy is 1 exactly when the limit is nonzero and the output differs from the current raw error.
- R9: Full-scale signed inputs, from the most negative to the most positive 32-bit value and back, move by one step with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_tick | input | 1 | One-clock strobe that marks a new phase-error sample |
| sync_clear | input | 1 | Loads the raw error into the output directly |
| rate_limit | input | 16 | Slew limit in ns/s, unsigned; 0 turns limiting off |
| rate_scale | input | 16 | Conversion factor from rate to per-tick step, binary point at bit 16 |
| phase_raw | input | 32 | Raw signed phase error in ps |
| phase_out | output | 32 | Limited signed phase error in ps |
| busy | output | 1 | Output has not yet reached the raw error |

## Verification
The assertions assume that rate_limit and rate_scale are quasi-static and change only between ticks. A step-bound check made on one tick would otherwise compare against a step computed from different settings. They also assume that phase_raw is a valid signed sample only in the cycle of a tick or a clear. The stimulus changes the limit and the scale only in cycles without a tick and loads each new starting point with a clear. Every tick lasts one cycle, so no sample is applied twice.

// File: rtl/slew_pkg.sv
package slew_pkg;
    localparam int unsigned PHASE_W_DEF = 32;
    localparam int unsigned LIMIT_W_DEF = 16;
    localparam int unsigned SCALE_W_DEF = 16;
    localparam int unsigned FRAC_SH_DEF = 16;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_SLEW  = 2'd2
    } slew_act_e;
endpackage

// File: rtl/slew_step_calc.sv
module slew_step_calc #(
    parameter int unsigned LIMIT_W = 16,
    parameter int unsigned SCALE_W = 16,
    parameter int unsigned FRAC_SH = 16,
    localparam int unsigned PROD_W = LIMIT_W + SCALE_W,
    localparam int unsigned STEP_W = PROD_W - FRAC_SH
) (
    input  logic [LIMIT_W-1:0] limit_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [STEP_W-1:0]  step_o
);
    logic [PROD_W-1:0] prod;
    logic [STEP_W-1:0] shifted;

    always_comb begin
        prod    = PROD_W'(limit_i) * PROD_W'(scale_i);
        shifted = prod[PROD_W-1:FRAC_SH];
        // R3: a nonzero limit always advances by at least one unit
        if (shifted == '0 && limit_i != '0) step_o = STEP_W'(1);
        else                                step_o = shifted;
    end
endmodule

// File: rtl/slew_track.sv
module slew_track #(
    parameter int unsigned PHASE_W = 32,
    parameter int unsigned STEP_W  = 16,
    localparam int unsigned EXT_W  = PHASE_W + 1
) (
    input  logic signed [PHASE_W-1:0] cur_i,
    input  logic signed [PHASE_W-1:0] raw_i,
    input  logic        [STEP_W-1:0]  step_i,
    output logic signed [PHASE_W-1:0] next_o
);
    logic signed [EXT_W-1:0] diff;
    logic        [EXT_W-1:0] mag;
    logic signed [EXT_W-1:0] step_ext;
    logic signed [EXT_W-1:0] moved;

    always_comb begin
        diff     = EXT_W'(raw_i) - EXT_W'(cur_i);
        mag      = diff[EXT_W-1] ? EXT_W'(-diff) : EXT_W'(diff);
        step_ext = EXT_W'(step_i);
        moved    = diff[EXT_W-1] ? (EXT_W'(cur_i) - step_ext)
                                 : (EXT_W'(cur_i) + step_ext);
        // R5 snap when within one step, R4 otherwise; never overshoots so no wrap (R9)
        if (mag <= EXT_W'(step_i)) next_o = raw_i;
        else                        next_o = moved[PHASE_W-1:0];
    end
endmodule

// File: rtl/phase_slew_limiter.sv
module phase_slew_limiter
    import slew_pkg::*;
#(
    parameter int unsigned PHASE_W = PHASE_W_DEF,
    parameter int unsigned LIMIT_W = LIMIT_W_DEF,
    parameter int unsigned SCALE_W = SCALE_W_DEF,
    parameter int unsigned FRAC_SH = FRAC_SH_DEF,
    localparam int unsigned STEP_W = LIMIT_W + SCALE_W - FRAC_SH
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      upd_tick,
    input  logic                      sync_clear,
    input  logic [LIMIT_W-1:0]        rate_limit,
    input  logic [SCALE_W-1:0]        rate_scale,
    input  logic signed [PHASE_W-1:0] phase_raw,
    output logic signed [PHASE_W-1:0] phase_out,
    output logic                      busy
);
    typedef struct packed {
        logic signed [PHASE_W-1:0] lim;
    } state_t;

    state_t                    state_d, state_q;
    slew_act_e                 act;
    logic        [STEP_W-1:0]  step;
    logic signed [PHASE_W-1:0] slewed;
    logic                      lim_off;

    slew_step_calc #(
        .LIMIT_W (LIMIT_W),
        .SCALE_W (SCALE_W),
        .FRAC_SH (FRAC_SH)
    ) u_step (
        .limit_i (rate_limit),
        .scale_i (rate_scale),
        .step_o  (step)
    );

    slew_track #(
        .PHASE_W (PHASE_W),
        .STEP_W  (STEP_W)
    ) u_track (
        .cur_i  (state_q.lim),
        .raw_i  (phase_raw),
        .step_i (step),
        .next_o (slewed)
    );

    assign lim_off = (rate_limit == '0);

    always_comb begin
        state_d = state_q;
        act     = ACT_HOLD;
        if (sync_clear)               act = ACT_LOAD;
        else if (upd_tick && lim_off) act = ACT_LOAD;
        else if (upd_tick)            act = ACT_SLEW;
        case (act)
            ACT_LOAD: state_d.lim = phase_raw;
            ACT_SLEW: state_d.lim = slewed;
            default:  state_d.lim = state_q.lim;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign phase_out = state_q.lim;
    assign busy      = !lim_off && (state_q.lim != phase_raw);

    function automatic logic [PHASE_W:0] abs_gap(input logic signed [PHASE_W-1:0] a,
                                                 input logic signed [PHASE_W-1:0] b);
        logic signed [PHASE_W:0] d;
        d = (PHASE_W+1)'(a) - (PHASE_W+1)'(b);
        return d[PHASE_W] ? (PHASE_W+1)'(-d) : (PHASE_W+1)'(d);
    endfunction

    // R2
    bypass_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_tick && rate_limit == '0) |=> (phase_out == $past(phase_raw)));

    // R4
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_tick && !sync_clear && rate_limit != '0)
        |=> (abs_gap(phase_out, $past(phase_out)) <= (PHASE_W+1)'($past(step))));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_tick && !sync_clear) |=> $stable(phase_out));

    // R7
    clear_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clear |=> (phase_out == $past(phase_raw)));

    // R8
    idle_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && upd_tick) |=> (phase_out == $past(phase_raw)));

    // R3
    step_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_limit != '0) |-> (step != '0));
endmodule

// File: tb/phase_slew_limiter_tb.sv
module phase_slew_limiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;

    localparam logic [15:0] V_LIM [NV] = '{16'd0, 16'd160, 16'd160, 16'd160, 16'd160,
                                           16'd1, 16'd65535, 16'd65535, 16'd160};
    localparam logic [15:0] V_SCL [NV] = '{16'd4096, 16'd4096, 16'd4096, 16'd4096, 16'd4096,
                                           16'd1, 16'd65535, 16'd65535, 16'd4096};
    localparam logic signed [31:0] V_START [NV] = '{32'sd100, 32'sd0, 32'sd0, 32'sd0, 32'sd0,
        32'sd0, -32'sd2147483648, 32'sd2147483647, -32'sd500};
    localparam logic signed [31:0] V_RAW [NV] = '{32'sd5000, 32'sd1000, -32'sd1000, 32'sd7, -32'sd10,
        32'sd50, 32'sd2147483647, -32'sd2147483648, -32'sd495};
    localparam logic signed [31:0] V_EXP [NV] = '{32'sd5000, 32'sd10, -32'sd10, 32'sd7, -32'sd10,
        32'sd1, -32'sd2147418114, 32'sd2147418113, -32'sd495};
    localparam string V_REQ [NV] = '{"R2", "R4", "R4", "R5", "R5", "R3", "R9", "R9", "R5"};

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               upd_tick = 1'b0;
    logic               sync_clear = 1'b0;
    logic [15:0]        rate_limit = '0;
    logic [15:0]        rate_scale = '0;
    logic signed [31:0] phase_raw = '0;
    logic signed [31:0] phase_out;
    logic               busy;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    phase_slew_limiter u_dut (
        .clk(clk), .rst_n(rst_n), .upd_tick(upd_tick), .sync_clear(sync_clear),
        .rate_limit(rate_limit), .rate_scale(rate_scale), .phase_raw(phase_raw),
        .phase_out(phase_out), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic signed [31:0] act, input logic signed [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input bit tk, input bit clr);
        @(negedge clk);
        upd_tick = tk;
        sync_clear = clr;
        @(negedge clk);
        upd_tick = 1'b0;
        sync_clear = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 out", phase_out, 0);
        check("R1 busy", 32'(busy), 0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            rate_limit = V_LIM[i];
            rate_scale = V_SCL[i];
            phase_raw  = V_START[i];
            pulse(1'b0, 1'b1);
            phase_raw = V_RAW[i];
            pulse(1'b1, 1'b0);
            check(V_REQ[i], phase_out, V_EXP[i]);
        end

        // R4 / R5 / R8: ramp to 25 in steps of 10
        @(negedge clk);
        rate_limit = 16'd160;
        rate_scale = 16'd4096;
        phase_raw  = 32'sd0;
        pulse(1'b0, 1'b1);
        phase_raw = 32'sd25;
        pulse(1'b1, 1'b0);
        check("R4 ramp1", phase_out, 10);
        check("R8 busy high", 32'(busy), 1);
        pulse(1'b1, 1'b0);
        check("R4 ramp2", phase_out, 20);
        pulse(1'b1, 1'b0);
        check("R5 ramp3", phase_out, 25);
        check("R8 busy low", 32'(busy), 0);

        // R6 hold without tick
        phase_raw = 32'sd500;
        repeat (3) @(negedge clk);
        check("R6 hold", phase_out, 25);
        check("R8 busy on raw change", 32'(busy), 1);

        // R7 clear beats tick
        pulse(1'b1, 1'b1);
        check("R7 clear with tick", phase_out, 500);

        // R7 clear with no tick, and busy stays low with the limit at zero (R8)
        rate_limit = 16'd0;
        phase_raw = -32'sd77;
        check("R8 busy off when bypassed", 32'(busy), 0);
        pulse(1'b0, 1'b1);
        check("R7 clear no tick", phase_out, -77);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule